// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

This block gets an I2C bus back from a device that is holding it. A device that was reset partway through a read can keep SDA low while it waits for clock edges that never arrive. After a one-cycle start request, the sequencer takes control of the bus pins. It first lets both lines float high and waits a settle interval. It then samples the bus. If either line is still low, it clocks SCL one pulse at a time and samples the bus again after every pulse. This goes on until the bus reads idle or a fixed number of pulses has been spent.

All delays are counted in ticks of an external microsecond strobe, so the pulse width does not depend on the system clock frequency. The pin outputs are open-drain enables: a 1 pulls the line low and a 0 releases it. The byte-transfer engine sits beside this block and is held in reset for the whole recovery. When the sequencer finishes, it raises a one-cycle completion strobe, shows the outcome on a fail flag and releases the engine.

Top module: `bus_unstick`

## Requirements
- R1: The bus counts as idle only when the synchronized SCL and SDA levels are both 1. A run that ends with fail_o=0 has sampled both lines high at its final check.
- R2: After an accepted start, both pin enables are 0. The first bus sample is taken only after SETTLE_TICKS tick strobes have passed.
- R3: In each recovery pulse, scl_oe_o is 1 for HALF_TICKS tick strobes. It then returns to 0 for HALF_TICKS tick strobes before the next sample.
- R4: A run issues at most MAX_TRIES SCL pulses. If the bus is still not idle after the last of them, the run ends with fail_o=1.
- R5: The bus is sampled before every pulse. As soon as a sample finds it idle, the run ends with no further pulse. A device that frees SDA on its Nth SCL rising edge, with N ≤ MAX_TRIES, therefore sees exactly N pulses.
- R6: xfer_rst_o is 1 from the cycle after an accepted start through the cycle in which done_o is 1. It is 0 in the following cycle, whatever the outcome.
- R7: done_o is high for exactly one cycle per run. fail_o is valid in that cycle and holds its value until the next accepted start.
- R8: sda_oe_o is never 1. Only SCL is driven during recovery.
- R9: A start request that arrives while a run is in progress is ignored. It neither restarts the pulse count nor produces an extra done_o.
- R10: If the bus is idle at the first sample, the run ends with fail_o=0 and no SCL pulse is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a recovery run |
| tick_i | input | 1 | One-cycle strobe every microsecond |
| scl_i | input | 1 | Sampled SCL line level (asynchronous) |
| sda_i | input | 1 | Sampled SDA line level (asynchronous) |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low (always 0) |
| xfer_rst_o | output | 1 | Holds the transfer engine in reset during a run |
| busy_o | output | 1 | A recovery run is in progress |
| done_o | output | 1 | One-cycle strobe at the end of a run |
| fail_o | output | 1 | Bus still held after all pulses were used |

## Verification
The bench models a device that holds SDA until it has counted a chosen number of SCL rising edges. It also models a device that holds SCL low for good. The counts tested are zero, one, exactly MAX_TRIES and one more than MAX_TRIES, plus random counts. A design with an off-by-one in the attempt limit would issue 99 or 101 pulses, or would report failure on a bus that its final pulse had freed. A design that skipped the per-pulse sample would keep clocking after release. A design that restarted on a second start request would show more pulses than the device asked for. The bench also measures how long SCL stays low, checks that the engine reset falls only after the done strobe, and checks that SDA is never pulled.

// File: rtl/bus_unstick_pkg.sv
package bus_unstick_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_CHECK  = 3'd2,
    ST_LOW    = 3'd3,
    ST_HIGH   = 3'd4,
    ST_DONE   = 3'd5
  } ru_state_t;

endpackage

// File: rtl/bus_unstick_sync.sv
module bus_unstick_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '1;
          else     chain[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '1;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/bus_unstick_timer.sv
module bus_unstick_timer #(
  parameter int LIMIT = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic tick_i,
  output logic expired_o
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear_i)                cnt <= '0;
    else if (tick_i && (cnt != LIM))   cnt <= cnt + 1'b1;
  end

  assign expired_o = (cnt == LIM);

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIM);

endmodule

// File: rtl/bus_unstick_fsm.sv
module bus_unstick_fsm
  import bus_unstick_pkg::*;
#(
  parameter int MAX_TRIES = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic bus_free_i,
  input  logic settle_exp_i,
  input  logic half_exp_i,
  output logic timer_clr_o,
  output logic scl_oe_o,
  output logic xfer_rst_o,
  output logic busy_o,
  output logic done_o,
  output logic fail_o
);

  localparam int TW = $clog2(MAX_TRIES + 1);
  localparam logic [TW-1:0] TMAX = TW'(MAX_TRIES);

  ru_state_t     state, nxt;
  logic [TW-1:0] tries;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (start_i)      nxt = ST_SETTLE;
      ST_SETTLE: if (settle_exp_i) nxt = ST_CHECK;
      ST_CHECK: begin
        if (bus_free_i || (tries == TMAX)) nxt = ST_DONE;
        else                                nxt = ST_LOW;
      end
      ST_LOW:    if (half_exp_i)   nxt = ST_HIGH;
      ST_HIGH:   if (half_exp_i)   nxt = ST_CHECK;
      ST_DONE:                     nxt = ST_IDLE;
      default:                     nxt = ST_IDLE;
    endcase
  end

  assign timer_clr_o = (nxt != state);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      tries      <= '0;
      scl_oe_o   <= 1'b0;
      xfer_rst_o <= 1'b0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      fail_o     <= 1'b0;
    end else begin
      state      <= nxt;
      scl_oe_o   <= (nxt == ST_LOW);
      xfer_rst_o <= (nxt != ST_IDLE);
      busy_o     <= (nxt != ST_IDLE);
      done_o     <= (nxt == ST_DONE);
      if (state == ST_IDLE && start_i) begin
        tries  <= '0;
        fail_o <= 1'b0;
      end
      if (state == ST_LOW && nxt == ST_HIGH)
        tries <= tries + 1'b1;
      if (state == ST_CHECK && nxt == ST_DONE)
        fail_o <= !bus_free_i;
    end
  end

  // R4: the pulse counter never passes the limit
  p_tries_bound_r4: assert property (@(posedge clk) disable iff (rst)
    tries <= TMAX);

  // R4: a failed run has used every pulse
  p_fail_full_r4: assert property (@(posedge clk) disable iff (rst)
    (done_o && fail_o) |-> (tries == TMAX));

  // R1: a successful finish follows an idle sample
  p_ok_idle_r1: assert property (@(posedge clk) disable iff (rst)
    (done_o && !fail_o) |-> $past(bus_free_i));

  // R3: SCL is pulled only after a sample found the bus held
  p_pull_after_check_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_oe_o) |-> ($past(state) == ST_CHECK && !$past(bus_free_i)));

  // R9: a start during a run leaves the pulse count alone
  p_no_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && state != ST_DONE && state != ST_LOW) |=> $stable(tries));

endmodule

// File: rtl/bus_unstick.sv
module bus_unstick #(
  parameter int MAX_TRIES    = 100,
  parameter int HALF_TICKS   = 10,
  parameter int SETTLE_TICKS = 10,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic tick_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_oe_o,
  output logic sda_oe_o,
  output logic xfer_rst_o,
  output logic busy_o,
  output logic done_o,
  output logic fail_o
);

  logic [1:0] lines_s;
  logic       bus_free;
  logic       tmr_clr;
  logic       settle_exp;
  logic       half_exp;

  bus_unstick_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({scl_i, sda_i}),
    .q_o (lines_s)
  );

  assign bus_free = lines_s[1] & lines_s[0];

  bus_unstick_timer #(.LIMIT(SETTLE_TICKS)) u_settle_tmr (
    .clk       (clk),
    .rst       (rst),
    .clear_i   (tmr_clr),
    .tick_i    (tick_i),
    .expired_o (settle_exp)
  );

  bus_unstick_timer #(.LIMIT(HALF_TICKS)) u_half_tmr (
    .clk       (clk),
    .rst       (rst),
    .clear_i   (tmr_clr),
    .tick_i    (tick_i),
    .expired_o (half_exp)
  );

  bus_unstick_fsm #(.MAX_TRIES(MAX_TRIES)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .bus_free_i   (bus_free),
    .settle_exp_i (settle_exp),
    .half_exp_i   (half_exp),
    .timer_clr_o  (tmr_clr),
    .scl_oe_o     (scl_oe_o),
    .xfer_rst_o   (xfer_rst_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .fail_o       (fail_o)
  );

  assign sda_oe_o = 1'b0;

  // R7: completion strobe lasts one cycle
  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R6: engine reset falls right after completion
  p_rst_release_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !xfer_rst_o);

  // R6: an accepted start puts the engine into reset
  p_rst_take_r6: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> xfer_rst_o);

  // R2: no pull on SCL in the cycle after a start
  p_release_first_r2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> !scl_oe_o);

endmodule

// File: tb/sim_bus_unstick.sv
module sim_bus_unstick;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int MAXT       = 100;
  localparam int HALF       = 10;
  localparam int SETTLE     = 10;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic tick = 1'b0;
  logic scl_oe, sda_oe, xrst, busy, done, fail;

  logic dev_scl_stuck = 1'b0;
  int   dev_edges_left = 0;
  logic scl_line, sda_line, scl_prev;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  int   pulses = 0;
  int   low_len = 0;
  int   low_min = 0;
  int   low_max = 0;
  logic oe_prev = 1'b0;
  logic sda_seen = 1'b0;
  logic xrst_drop = 1'b0;
  logic in_run = 1'b0;
  int   done_count = 0;

  assign scl_line = !scl_oe && !dev_scl_stuck;
  assign sda_line = !sda_oe && (dev_edges_left == 0);

  bus_unstick #(.MAX_TRIES(MAXT), .HALF_TICKS(HALF), .SETTLE_TICKS(SETTLE), .SYNC_STAGES(2)) u0 (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start),
    .tick_i     (tick),
    .scl_i      (scl_line),
    .sda_i      (sda_line),
    .scl_oe_o   (scl_oe),
    .sda_oe_o   (sda_oe),
    .xfer_rst_o (xrst),
    .busy_o     (busy),
    .done_o     (done),
    .fail_o     (fail)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cyc  <= cyc + 1;
    tick <= ((cyc % TICK_DIV) == 0);
  end

  // device model and monitor, all at the falling edge
  always @(negedge clk) begin
    scl_prev <= scl_line;
    if (scl_line && !scl_prev && dev_edges_left > 0)
      dev_edges_left <= dev_edges_left - 1;
    oe_prev <= scl_oe;
    if (scl_oe && !oe_prev) begin
      pulses  <= pulses + 1;
      low_len <= 1;
    end else if (scl_oe) begin
      low_len <= low_len + 1;
    end else if (oe_prev) begin
      if (low_min == 0 || low_len < low_min) low_min <= low_len;
      if (low_len > low_max) low_max <= low_len;
    end
    if (sda_oe) sda_seen <= 1'b1;
    if (in_run && !xrst && !done) xrst_drop <= 1'b1;
    if (done) done_count <= done_count + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_pulses(input int n, input bit stuck);
    if (stuck) return MAXT;
    return (n <= MAXT) ? n : MAXT;
  endfunction

  function automatic bit exp_fail(input int n, input bit stuck);
    return stuck || (n > MAXT);
  endfunction

  task automatic run_case(input int n, input bit stuck, input bit poke);
    int wait_c;
    @(negedge clk);
    dev_edges_left = n;
    dev_scl_stuck  = stuck;
    pulses = 0; low_min = 0; low_max = 0;
    sda_seen = 1'b0; xrst_drop = 1'b0; done_count = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    in_run = 1'b1;
    check(xrst == 1'b1, "R6 reset taken", int'(xrst), 1);
    check(scl_oe == 1'b0 && sda_oe == 1'b0, "R2 released at entry", int'(scl_oe), 0);
    wait_c = 0;
    while (!done && wait_c < 30000) begin
      @(negedge clk);
      wait_c++;
      if (poke && pulses == 2 && wait_c % 50 == 0) begin
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_c++;
      end
    end
    check(done == 1'b1, "R7 done reached", int'(done), 1);
    check(pulses == exp_pulses(n, stuck), "R4/R5 pulse count", pulses, exp_pulses(n, stuck));
    check(fail == exp_fail(n, stuck), "R4 fail flag", int'(fail), int'(exp_fail(n, stuck)));
    check(xrst == 1'b1, "R6 reset held at done", int'(xrst), 1);
    @(negedge clk);
    in_run = 1'b0;
    check(done == 1'b0, "R7 done one cycle", int'(done), 0);
    check(xrst == 1'b0, "R6 reset released", int'(xrst), 0);
    check(!xrst_drop, "R6 reset held through run", int'(xrst_drop), 0);
    check(fail == exp_fail(n, stuck), "R7 fail held", int'(fail), int'(exp_fail(n, stuck)));
    check(!sda_seen, "R8 SDA never pulled", int'(sda_seen), 0);
    if (pulses > 0)
      check(low_min >= HALF*TICK_DIV - 1 && low_max <= HALF*TICK_DIV + TICK_DIV + 1,
            "R3 SCL low width", low_max, HALF*TICK_DIV);
    repeat (20) @(negedge clk);
    check(done_count == 1, "R9 single done", done_count, 1);
    dev_edges_left = 0;
    dev_scl_stuck  = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h1F2E));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(scl_oe == 0 && sda_oe == 0 && xrst == 0 && done == 0 && busy == 0 && fail == 0,
          "R7 reset state", int'({scl_oe, sda_oe, xrst, done, busy, fail}), 0);
    // R10 / R1: idle bus, no pulse
    run_case(0, 1'b0, 1'b0);
    // R5: one pulse frees the bus
    run_case(1, 1'b0, 1'b0);
    // R9: extra start mid-run ignored
    run_case(5, 1'b0, 1'b1);
    // R5: last permitted pulse frees the bus
    run_case(MAXT, 1'b0, 1'b0);
    // R4: one too many
    run_case(MAXT + 1, 1'b0, 1'b0);
    // R4 / R1: SCL held low by the device
    run_case(0, 1'b1, 1'b0);
    for (int k = 0; k < 6; k++) begin
      int n;
      n = int'($urandom % 110);
      run_case(n, 1'b0, 1'b0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int w = 0; w < WATCHDOG; w++) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule